// File: doc/BRIEF.md
# Reciprocal Square Root Operand Pre-Scaler

This block sits in front of an iterative single-precision reciprocal-square-root datapath. Each accepted operand is classified. Operands that the iteration cannot handle (NaN, negative values, positive infinity, zero) are resolved on the spot into fixed operand and seed words, and the iteration is told to stand down. Ordinary positive operands go through with a zero seed and a request to iterate.

Ordinary operands with a very small biased exponent are first multiplied by 2^64 so that the iteration stays inside the normal range. Positive subnormals are normalized as part of that multiply. An 8-bit adjust code tells the later exponent-correction stage whether this rescale took place.

The result is registered. `out_valid` follows `in_valid` one cycle later, and the output word holds its value in any cycle where nothing is accepted.

Top module: `rsqrt_prescale`

## Requirements
- R1: A NaN input (exponent field 255, fraction nonzero) gives operand and seed both 0xFFFFFFFF. Invalid is set exactly when input bit 22 (the quiet bit) is 0.
- R2: A negative nonzero input gives operand and seed both 0xFFFFFFFF with invalid set. This covers negative infinity and negative subnormals.
- R3: Positive infinity (0x7F800000) gives operand and seed both 0x7F800000, with invalid clear.
- R4: Positive and negative zero both pass the operand through unchanged and give a seed of 0x3F800000 (1.0), with invalid clear.
- R5: A positive finite input with biased exponent field above 24 passes the operand through unchanged, with adjust code 0x00.
- R6: A positive normal input with biased exponent field from 1 to 24 leaves sign and fraction as they are, adds 64 to the exponent field, and gives adjust code 0xE0.
- R7: A positive subnormal input is normalized and scaled by 2^64 exactly: the leading fraction bit becomes the hidden bit, the remaining bits shift up, the exponent field becomes (leading-bit index + 42), and the adjust code is 0xE0.
- R8: On the ordinary path (R5 to R7) the seed is 0, the continue flag is 1 and invalid is 0. Every special case (R1 to R4) gives a continue flag of 0 and an adjust code of 0x00.
- R9: After reset every output is 0. `out_valid` equals `in_valid` from the previous edge, and the result outputs hold their values across cycles where `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present this cycle |
| in_operand | input | 32 | Single-precision operand |
| out_valid | output | 1 | Result registered from last cycle's operand |
| out_operand | output | 32 | Adjusted operand for the iteration |
| out_seed | output | 32 | Seed value (fixed result for special cases) |
| out_adjust | output | 8 | Adjust code: 0x00 or 0xE0 |
| out_continue | output | 1 | High when the iteration must run |
| out_invalid | output | 1 | Invalid-operation indication |

## Verification
The assertions take for granted that `in_valid` and `in_operand` are driven to known values in every cycle once reset is released. The range check on the scaled exponent also relies on the 2^64 shift never reaching the all-ones exponent when it starts from field 24 or lower. The bench drives both inputs at every falling edge, including idle cycles, so nothing is left unknown. It covers all seven operand classes both with directed edge values (exponent fields 0, 1, 24 and 25, every leading-bit position of a subnormal, and both quiet-bit settings of a NaN) and with random draws inside each class.

// File: rtl/rsqrt_prescale_pkg.sv
package rsqrt_prescale_pkg;

  localparam int WORD_W = 32;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int POS_W  = $clog2(FRAC_W);
  localparam logic [EXP_W-1:0] EXP_ONES = '1;

  localparam logic [WORD_W-1:0] QNAN_ALL  = '1;
  localparam logic [WORD_W-1:0] POS_INF   = {1'b0, EXP_ONES, {FRAC_W{1'b0}}};
  localparam logic [WORD_W-1:0] ONE_VALUE = {2'b00, {(EXP_W-1){1'b1}}, {FRAC_W{1'b0}}};

  typedef enum logic [2:0] {
    K_NAN   = 3'd0,
    K_NEG   = 3'd1,
    K_PINF  = 3'd2,
    K_ZERO  = 3'd3,
    K_SUB   = 3'd4,
    K_SMALL = 3'd5,
    K_LARGE = 3'd6
  } op_kind_e;

  typedef struct packed {
    logic [WORD_W-1:0] operand;
    logic [WORD_W-1:0] seed;
    logic [7:0]        adjust;
    logic              cont;
    logic              invalid;
  } prescale_res_t;

  function automatic logic [EXP_W-1:0] f_exp(input logic [WORD_W-1:0] w);
    return w[WORD_W-2 -: EXP_W];
  endfunction

  function automatic logic [FRAC_W-1:0] f_frac(input logic [WORD_W-1:0] w);
    return w[FRAC_W-1:0];
  endfunction

  // Index of the most significant set bit of a fraction (0 when none).
  function automatic logic [POS_W-1:0] f_lead_pos(input logic [FRAC_W-1:0] fr);
    logic [POS_W-1:0] pos;
    pos = '0;
    for (int i = 0; i < FRAC_W; i++) begin
      if (fr[i]) pos = POS_W'(i);
    end
    return pos;
  endfunction

  // Exponent field after adding scale_pow to a normal exponent.
  function automatic logic [EXP_W-1:0] f_scale_normal(input logic [EXP_W-1:0] e,
                                                      input int unsigned scale_pow);
    return e + EXP_W'(scale_pow);
  endfunction

  // Exponent field of a subnormal once normalized and scaled.
  function automatic logic [EXP_W-1:0] f_scale_sub_exp(input logic [POS_W-1:0] pos,
                                                       input int unsigned scale_pow);
    int signed e;
    e = int'(pos) + 1 + int'(scale_pow) - FRAC_W;
    return EXP_W'(e);
  endfunction

  // Fraction of a subnormal once the leading bit becomes the hidden bit.
  function automatic logic [FRAC_W-1:0] f_norm_frac(input logic [FRAC_W-1:0] fr,
                                                    input logic [POS_W-1:0] pos);
    logic [FRAC_W:0] wide;
    wide = {1'b0, fr} << (FRAC_W - int'(pos));
    return wide[FRAC_W-1:0];
  endfunction

endpackage

// File: rtl/rsqrt_prescale_classify.sv
module rsqrt_prescale_classify
  import rsqrt_prescale_pkg::*;
#(
  parameter int SMALL_EXP_LIMIT = 24
) (
  input  logic [WORD_W-1:0] operand,
  output op_kind_e          kind,
  output logic [6:0]        kind_hits
);

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              sign_f;
  logic              mag_zero;
  logic              exp_max;
  logic              exp_min;

  assign sign_f   = operand[WORD_W-1];
  assign exp_f    = f_exp(operand);
  assign frac_f   = f_frac(operand);
  assign mag_zero = (operand[WORD_W-2:0] == '0);
  assign exp_max  = (exp_f == EXP_ONES);
  assign exp_min  = (exp_f == '0);

  // Individual class detectors, brought out for the one-hot check.
  logic hit_nan, hit_neg, hit_pinf, hit_zero, hit_sub, hit_small, hit_large;

  assign hit_nan   = exp_max && (frac_f != '0);
  assign hit_neg   = !hit_nan && sign_f && !mag_zero;
  assign hit_pinf  = exp_max && (frac_f == '0) && !sign_f;
  assign hit_zero  = mag_zero;
  assign hit_sub   = !sign_f && exp_min && !mag_zero;
  assign hit_small = !sign_f && !exp_min && (int'(exp_f) <= SMALL_EXP_LIMIT);
  assign hit_large = !sign_f && !exp_max && (int'(exp_f) > SMALL_EXP_LIMIT);

  assign kind_hits = {hit_large, hit_small, hit_sub, hit_zero, hit_pinf, hit_neg, hit_nan};

  // Priority: NaN, negative, +inf, zero, then the ordinary classes.
  always_comb begin
    if (hit_nan)        kind = K_NAN;
    else if (hit_neg)   kind = K_NEG;
    else if (hit_pinf)  kind = K_PINF;
    else if (hit_zero)  kind = K_ZERO;
    else if (hit_sub)   kind = K_SUB;
    else if (hit_small) kind = K_SMALL;
    else                kind = K_LARGE;
  end

endmodule

// File: rtl/rsqrt_prescale_scale.sv
module rsqrt_prescale_scale
  import rsqrt_prescale_pkg::*;
#(
  parameter int unsigned SCALE_POW = 64
) (
  input  logic [WORD_W-1:0] operand,
  input  op_kind_e          kind,
  output logic [WORD_W-1:0] scaled,
  output logic              scale_hit
);

  logic [POS_W-1:0]  lead;
  logic [EXP_W-1:0]  exp_norm;
  logic [EXP_W-1:0]  exp_sub;
  logic [FRAC_W-1:0] frac_sub;

  assign lead     = f_lead_pos(f_frac(operand));
  assign exp_norm = f_scale_normal(f_exp(operand), SCALE_POW);
  assign exp_sub  = f_scale_sub_exp(lead, SCALE_POW);
  assign frac_sub = f_norm_frac(f_frac(operand), lead);

  assign scale_hit = (kind == K_SUB) || (kind == K_SMALL);

  always_comb begin
    unique case (kind)
      K_SUB:   scaled = {1'b0, exp_sub, frac_sub};
      K_SMALL: scaled = {1'b0, exp_norm, f_frac(operand)};
      default: scaled = operand;
    endcase
  end

endmodule

// File: rtl/rsqrt_prescale_resolve.sv
module rsqrt_prescale_resolve
  import rsqrt_prescale_pkg::*;
#(
  parameter logic [7:0] ADJ_TAG = 8'hE0
) (
  input  logic [WORD_W-1:0] operand,
  input  logic [WORD_W-1:0] scaled,
  input  op_kind_e          kind,
  output prescale_res_t     res
);

  localparam int QUIET_BIT = FRAC_W - 1;

  always_comb begin
    res = '0;
    unique case (kind)
      K_NAN: begin
        res.operand = QNAN_ALL;
        res.seed    = QNAN_ALL;
        res.invalid = !operand[QUIET_BIT];
      end
      K_NEG: begin
        res.operand = QNAN_ALL;
        res.seed    = QNAN_ALL;
        res.invalid = 1'b1;
      end
      K_PINF: begin
        res.operand = POS_INF;
        res.seed    = POS_INF;
      end
      K_ZERO: begin
        res.operand = operand;
        res.seed    = ONE_VALUE;
      end
      K_SUB, K_SMALL: begin
        res.operand = scaled;
        res.adjust  = ADJ_TAG;
        res.cont    = 1'b1;
      end
      default: begin
        res.operand = operand;
        res.cont    = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/rsqrt_prescale.sv
module rsqrt_prescale
  import rsqrt_prescale_pkg::*;
#(
  parameter int unsigned SCALE_POW       = 64,
  parameter int          SMALL_EXP_LIMIT = 24,
  parameter logic [7:0]  ADJ_TAG         = 8'hE0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_operand,
  output logic        out_valid,
  output logic [31:0] out_operand,
  output logic [31:0] out_seed,
  output logic [7:0]  out_adjust,
  output logic        out_continue,
  output logic        out_invalid
);

  op_kind_e          kind;
  logic [6:0]        kind_hits;
  logic [WORD_W-1:0] scaled;
  logic              scale_hit;
  prescale_res_t     res;
  prescale_res_t     res_q;
  logic              valid_q;

  rsqrt_prescale_classify #(.SMALL_EXP_LIMIT(SMALL_EXP_LIMIT)) u_classify (
    .operand   (in_operand),
    .kind      (kind),
    .kind_hits (kind_hits)
  );

  rsqrt_prescale_scale #(.SCALE_POW(SCALE_POW)) u_scale (
    .operand   (in_operand),
    .kind      (kind),
    .scaled    (scaled),
    .scale_hit (scale_hit)
  );

  rsqrt_prescale_resolve #(.ADJ_TAG(ADJ_TAG)) u_resolve (
    .operand (in_operand),
    .scaled  (scaled),
    .kind    (kind),
    .res     (res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) res_q <= res;
    end
  end

  assign out_valid    = valid_q;
  assign out_operand  = res_q.operand;
  assign out_seed     = res_q.seed;
  assign out_adjust   = res_q.adjust;
  assign out_continue = res_q.cont;
  assign out_invalid  = res_q.invalid;

  // Class detectors never overlap (all requirements rely on one class).
  a_r8_kind_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(kind_hits));

  // A rescaled operand lands strictly above the small range, below all-ones.
  a_r6_scaled_range: assert property (@(posedge clk) disable iff (!rst_n)
    scale_hit |-> (int'(f_exp(scaled)) > SMALL_EXP_LIMIT) && (f_exp(scaled) != EXP_ONES)
                  && !scaled[WORD_W-1]);

  // R7: a subnormal scales to a normal number.
  a_r7_sub_normalized: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_SUB) |-> (f_exp(scaled) != '0));

  // R1/R2: invalid results carry the canonical NaN on both words.
  a_r2_invalid_nan: assert property (@(posedge clk) disable iff (!rst_n)
    out_invalid |-> (out_operand == QNAN_ALL) && (out_seed == QNAN_ALL) && !out_continue);

  a_r8_cont_seed_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_continue |-> (out_seed == '0) && !out_invalid);

  a_r8_special_no_adjust: assert property (@(posedge clk) disable iff (!rst_n)
    !out_continue |-> (out_adjust == 8'h00));

  a_r6_adjust_values: assert property (@(posedge clk) disable iff (!rst_n)
    (out_adjust != 8'h00) |-> (out_adjust == ADJ_TAG));

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_operand) && $stable(out_seed) && $stable(out_adjust));

endmodule

// File: tb/tb_rsqrt_prescale.sv
module tb_rsqrt_prescale;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_operand = '0;
  logic        out_valid;
  logic [31:0] out_operand;
  logic [31:0] out_seed;
  logic [7:0]  out_adjust;
  logic        out_continue;
  logic        out_invalid;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  rsqrt_prescale dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_operand(in_operand),
    .out_valid(out_valid), .out_operand(out_operand), .out_seed(out_seed),
    .out_adjust(out_adjust), .out_continue(out_continue), .out_invalid(out_invalid)
  );

  // Reference state: what the outputs should show after the next edge.
  logic        m_valid = 0;
  logic [31:0] m_op = 0, m_seed = 0;
  logic [7:0]  m_adj = 0;
  logic        m_cont = 0, m_inv = 0;
  string       m_tag = "R9";

  task automatic model(input logic [31:0] a);
    logic        s;
    int          e;
    logic [23:0] m;
    s = a[31];
    e = int'(a[30:23]);
    m_op = a; m_seed = 0; m_adj = 0; m_cont = 0; m_inv = 0;
    if (e == 255 && a[22:0] != 0) begin
      m_op = 32'hFFFFFFFF; m_seed = 32'hFFFFFFFF; m_inv = !a[22]; m_tag = "R1";
    end else if (s && a[30:0] != 0) begin
      m_op = 32'hFFFFFFFF; m_seed = 32'hFFFFFFFF; m_inv = 1; m_tag = "R2";
    end else if (e == 255) begin
      m_op = 32'h7F800000; m_seed = 32'h7F800000; m_tag = "R3";
    end else if (a[30:0] == 0) begin
      m_seed = 32'h3F800000; m_tag = "R4";
    end else begin
      m_cont = 1;
      if (e > 24) begin
        m_tag = "R5";
      end else if (e > 0) begin
        m_adj = 8'hE0; m_op = {1'b0, 8'(e + 64), a[22:0]}; m_tag = "R6";
      end else begin
        int ee = 1;
        m = {1'b0, a[22:0]};
        while (m[23] == 1'b0) begin
          m = m << 1;
          ee = ee - 1;
        end
        m_adj = 8'hE0; m_op = {1'b0, 8'(ee + 64), m[22:0]}; m_tag = "R7";
      end
    end
  endtask

  task automatic compare(input string tag);
    vectors++;
    if (out_valid !== m_valid || out_operand !== m_op || out_seed !== m_seed ||
        out_adjust !== m_adj || out_continue !== m_cont || out_invalid !== m_inv) begin
      miscompares++;
      $display("FAIL %s: got v=%0b op=%08h seed=%08h adj=%02h cont=%0b inv=%0b, expected v=%0b op=%08h seed=%08h adj=%02h cont=%0b inv=%0b",
               tag, out_valid, out_operand, out_seed, out_adjust, out_continue, out_invalid,
               m_valid, m_op, m_seed, m_adj, m_cont, m_inv);
    end
  endtask

  // Drive at a falling edge, check at the following falling edge.
  task automatic step(input logic v, input logic [31:0] a);
    string tag;
    in_valid = v;
    in_operand = a;
    m_valid = v;
    if (v) model(a);
    tag = v ? m_tag : "R9";
    @(negedge clk);
    compare(tag);
  endtask

  function automatic logic [31:0] pick(input int cls);
    logic [31:0] r;
    r = $urandom;
    case (cls)
      0: return {r[31], 8'hFF, r[22:1], 1'b1};
      1: return {1'b1, r[30:0] | 31'h1};
      2: return {1'b0, 8'(1 + (r[30:23] % 24)), r[22:0]};
      3: return {1'b0, 8'h00, r[22:0] >> (r[31:27] % 23)} | 32'h1;
      4: return {1'b0, 8'(25 + (r[30:23] % 230)), r[22:0]};
      default: return {r[31], 31'h0};
    endcase
  endfunction

  initial begin
    logic [31:0] dir [$];
    repeat (3) @(negedge clk);
    // R9: reset values
    compare("R9");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R9");

    dir = '{32'h00000000, 32'h80000000, 32'h7F800000, 32'hFF800000, 32'h7FC00000,
            32'h7F800001, 32'hFFBFFFFF, 32'hFFFFFFFF, 32'h00000001, 32'h007FFFFF,
            32'h00400000, 32'h00800000, 32'h0C000000, 32'h0C7FFFFF, 32'h0C800000,
            32'h3F800000, 32'h7F7FFFFF, 32'h80000001, 32'hBF800000, 32'h00123456};
    foreach (dir[i]) begin
      step(1'b1, dir[i]);
      step(1'b0, 32'hDEADBEEF);   // R9: idle cycle must not disturb outputs
    end
    // R7: every leading-bit position of a subnormal
    for (int p = 0; p < 23; p++) step(1'b1, 32'h1 << p);
    // Random mix across classes, with idle cycles in between
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] | r[1], pick(int'(r[7:4] % 6)));
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      miscompares++;
      $display("FAIL R9: watchdog expired, got running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule